// File: doc/BRIEF.md
# Negotiated-Width Byte Lane Striper

This block spreads a byte stream over a group of parallel lanes. The number of lanes in use is chosen at run time. The first byte of a word goes to lane 0 and each following byte goes to the next lane, so byte k lands on lane k mod N, where N is the active width. A word holds N bytes. It leaves on a wide output bus with one common valid. Each lane also carries its own lane-valid and pad flag, so that the receiving reassembler can drop filler bytes and unused lanes.

The active width comes from a negotiation between two capability masks, one for this end and one for the partner. The result is the widest lane count that both masks offer, taken from a fixed set of widths that includes the non-power-of-two width 12. Negotiation runs once after reset. It runs again whenever `reneg_req` is pulsed, but the new width only takes effect at a word boundary. If the two ends share nothing wider than one lane, the link runs on one lane and raises `degraded`.

Both stream sides use valid/ready. An input byte is taken on a clock edge where `in_valid` and `in_ready` are both high. A word is taken on an edge where `out_valid` and `out_ready` are both high. While a word is held by back-pressure, `out_valid`, `out_data`, `out_lane_valid` and `out_pad` stay frozen and `in_ready` is low. In the cycle the held word is taken, a new byte may be accepted.

Top module: `lane_striper`

## Requirements
- R1: Within a word, the k-th accepted byte (counting from 0) appears on lane k, bits [8k+7:8k] of `out_data`, and every word starts at lane 0.
- R2: Capability mask bit i offers width 1, 2, 4, 8, 12, 16, 32 for i = 0..6. Width 1 is always usable, even when both masks are zero, and widths above `MAX_LANES` are never chosen.
- R3: `active_width` is the largest width offered by both masks. `degraded` is 1 exactly when the chosen width is 1.
- R4: Negotiation happens in the first cycle after reset, and `in_ready` is low during reset and in that cycle. A `reneg_req` pulse takes effect only when no word is partly filled and no word is held. While it is pending, no new word starts.
- R5: A word completes after N bytes, or early on a byte marked `in_last`. The unfilled lanes below N then carry 0x00, with both `out_pad` and `out_lane_valid` set.
- R6: While `out_valid` is high, `out_lane_valid` is set for every lane below N, and lanes at or above N have `out_lane_valid` and `out_pad` low.
- R7: While `out_valid` is high and `out_ready` is low, the word and its flags stay stable on the next cycle and `in_ready` is low.
- R8: When a held word is taken in the same cycle, `in_ready` is high, so at width 1 with `out_ready` held high the block accepts one byte every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_cap | input | 7 | Widths this end supports (R2 encoding) |
| partner_cap | input | 7 | Widths the partner supports (R2 encoding) |
| reneg_req | input | 1 | One-cycle request to negotiate again |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of a transfer |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| out_valid | output | 1 | A complete word is presented |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | MAX_LANES*8 | Lane j byte in bits [8j+7:8j] |
| out_lane_valid | output | MAX_LANES | Per-lane valid, gated by out_valid |
| out_pad | output | MAX_LANES | Per-lane pad flag, gated by out_valid |
| active_width | output | 6 | Negotiated lane count |
| degraded | output | 1 | Link fell back to one lane |

## Verification
The embedded properties check these rules on every cycle:
- the negotiated width always belongs to the legal set;
- `degraded` agrees with a single-lane result;
- the width changes only at an idle word boundary;
- a presented word covers exactly the active lanes;
- a held word stays frozen while `in_ready` is low.

Some behaviours only the bench scenarios can show. These are the byte-to-lane order, the pad values, the choice of the highest common width for particular mask pairs (including 12 and the fallback case), how a mid-word renegotiation is deferred, and full-rate acceptance at width 1.

// File: rtl/lstr_pkg.sv
`timescale 1ns/1ps
package lstr_pkg;
  localparam int NUM_WIDTHS = 7;

  // lane count offered by capability bit idx
  function automatic int width_of(input int idx);
    case (idx)
      0: width_of = 1;
      1: width_of = 2;
      2: width_of = 4;
      3: width_of = 8;
      4: width_of = 12;
      5: width_of = 16;
      default: width_of = 32;
    endcase
  endfunction
endpackage

// File: rtl/lstr_width_neg.sv
`timescale 1ns/1ps
module lstr_width_neg #(
  parameter int MAX_LANES = 32,
  parameter int IDX_W = 3,
  parameter int LW = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [lstr_pkg::NUM_WIDTHS-1:0] local_cap,
  input  logic [lstr_pkg::NUM_WIDTHS-1:0] partner_cap,
  input  logic reneg_req,
  input  logic boundary,
  output logic pend,
  output logic [LW-1:0] lanes,
  output logic degraded
);
  localparam int NW = lstr_pkg::NUM_WIDTHS;

  logic [NW-1:0] fit, common;
  logic [IDX_W-1:0] best, idx_q;

  always_comb begin
    for (int i = 0; i < NW; i++) fit[i] = (lstr_pkg::width_of(i) <= MAX_LANES);
    common = (local_cap & partner_cap & fit) | NW'(1);
    best = '0;
    for (int i = 0; i < NW; i++) if (common[i]) best = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b1;
      idx_q    <= '0;
      degraded <= 1'b1;
    end else if (pend && boundary) begin
      idx_q    <= best;
      degraded <= ~|common[NW-1:1];
      pend     <= reneg_req;
    end else if (reneg_req) begin
      pend <= 1'b1;
    end
  end

  assign lanes = LW'(lstr_pkg::width_of(int'(idx_q)));

  p_legal_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lanes == 1 || lanes == 2 || lanes == 4 || lanes == 8 || lanes == 12 ||
     lanes == 16 || lanes == 32) && (int'(lanes) <= MAX_LANES));

  p_degraded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    degraded == (lanes == LW'(1)));

  p_width_at_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lanes) |-> $past(pend && boundary));
endmodule

// File: rtl/lstr_lane_slot.sv
`timescale 1ns/1ps
module lstr_lane_slot #(
  parameter int BYTE_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic wr,
  input  logic pad_set,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout,
  output logic lv,
  output logic pad
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout <= '0; lv <= 1'b0; pad <= 1'b0;
    end else if (wr) begin
      dout <= din; lv <= 1'b1; pad <= 1'b0;
    end else if (pad_set) begin
      dout <= '0; lv <= 1'b1; pad <= 1'b1;
    end else if (clr) begin
      dout <= '0; lv <= 1'b0; pad <= 1'b0;
    end
  end
endmodule

// File: rtl/lane_striper.sv
`timescale 1ns/1ps
module lane_striper #(
  parameter int MAX_LANES = 32,
  parameter int BYTE_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [lstr_pkg::NUM_WIDTHS-1:0] local_cap,
  input  logic [lstr_pkg::NUM_WIDTHS-1:0] partner_cap,
  input  logic reneg_req,
  input  logic in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic in_last,
  output logic in_ready,
  output logic out_valid,
  input  logic out_ready,
  output logic [MAX_LANES*BYTE_W-1:0] out_data,
  output logic [MAX_LANES-1:0] out_lane_valid,
  output logic [MAX_LANES-1:0] out_pad,
  output logic [$clog2(MAX_LANES+1)-1:0] active_width,
  output logic degraded
);
  localparam int LW = $clog2(MAX_LANES + 1);
  localparam int CNT_W = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1;
  localparam int IDX_W = $clog2(lstr_pkg::NUM_WIDTHS);

  logic [CNT_W-1:0] cnt;
  logic ov, pend, boundary, acc, fire, complete, last_slot;
  logic [LW-1:0] lanes;
  logic [MAX_LANES-1:0] lv_q, pad_q, lane_mask;

  assign boundary  = (cnt == '0) && !ov;
  assign in_ready  = !(pend && cnt == '0) && (!ov || out_ready);
  assign acc       = in_valid && in_ready;
  assign fire      = ov && out_ready;
  assign last_slot = (LW'(cnt) == lanes - LW'(1));
  assign complete  = acc && (last_slot || in_last);

  lstr_width_neg #(.MAX_LANES(MAX_LANES), .IDX_W(IDX_W), .LW(LW)) neg_i (
    .clk(clk), .rst_n(rst_n), .local_cap(local_cap), .partner_cap(partner_cap),
    .reneg_req(reneg_req), .boundary(boundary), .pend(pend), .lanes(lanes),
    .degraded(degraded));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ov  <= 1'b0;
    end else begin
      if (complete) cnt <= '0;
      else if (acc) cnt <= cnt + CNT_W'(1);
      if (complete) ov <= 1'b1;
      else if (fire) ov <= 1'b0;
    end
  end

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    logic wr_j, pad_j;
    assign wr_j  = acc && (cnt == CNT_W'(j));
    assign pad_j = complete && (LW'(j) > LW'(cnt)) && (LW'(j) < lanes);
    assign lane_mask[j] = (LW'(j) < lanes);

    lstr_lane_slot #(.BYTE_W(BYTE_W)) slot_i (
      .clk(clk), .rst_n(rst_n), .clr(fire), .wr(wr_j), .pad_set(pad_j),
      .din(in_data), .dout(out_data[j*BYTE_W +: BYTE_W]),
      .lv(lv_q[j]), .pad(pad_q[j]));
  end

  assign out_valid      = ov;
  assign out_lane_valid = lv_q & {MAX_LANES{ov}};
  assign out_pad        = pad_q & {MAX_LANES{ov}};
  assign active_width   = lanes;

  p_word_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_lane_valid == lane_mask));

  p_idle_above_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_lane_valid | out_pad) & ~lane_mask) == '0);

  p_hold_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_pad)));

  p_stall_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_take_on_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !pend) |-> in_ready);
endmodule

// File: tb/lane_striper_tb.sv
`timescale 1ns/1ps
module lane_striper_tb_top;
  localparam int CLK_P = 10;
  localparam int ML = 32;
  localparam int WT[7] = '{1, 2, 4, 8, 12, 16, 32};

  logic clk = 0, rst_n = 0;
  logic [6:0] loc_cap = 7'h7F, par_cap = 7'h7F;
  logic reneg_req = 0, in_valid = 0, in_last = 0, out_ready = 0;
  logic [7:0] in_data = 0;
  logic in_ready, out_valid, degraded;
  logic [ML*8-1:0] out_data;
  logic [ML-1:0] out_lane_valid, out_pad;
  logic [5:0] active_width;

  int n_checks = 0, n_fail = 0, rdy_mode = 0, stalls = 0;
  int model_n = 1, model_cnt = 0;
  bit pend_model = 1;
  logic [ML*8-1:0] cw_data = '0;
  logic [ML-1:0] cw_lv = '0, cw_pad = '0;
  logic [ML*8-1:0] q_data[$];
  logic [ML-1:0] q_lv[$], q_pad[$];

  always #(CLK_P/2) clk = ~clk;

  lane_striper dut_i (
    .clk(clk), .rst_n(rst_n), .local_cap(loc_cap), .partner_cap(par_cap),
    .reneg_req(reneg_req), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_lane_valid(out_lane_valid), .out_pad(out_pad),
    .active_width(active_width), .degraded(degraded));

  function automatic int exp_width(input logic [6:0] a, input logic [6:0] b);
    logic [6:0] c = (a & b) | 7'd1;
    for (int i = 6; i >= 0; i--) if (c[i] && WT[i] <= ML) return WT[i];
    return 1;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [ML*8-1:0] act,
                       input logic [ML*8-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_accept(input logic [7:0] d, input bit last);
    if (model_cnt == 0 && pend_model) begin
      model_n = exp_width(loc_cap, par_cap);
      pend_model = 0;
    end
    cw_data[model_cnt*8 +: 8] = d;
    cw_lv[model_cnt] = 1'b1;
    if (model_cnt == model_n - 1 || last) begin
      for (int j = model_cnt + 1; j < model_n; j++) begin
        cw_lv[j] = 1'b1; cw_pad[j] = 1'b1;
      end
      q_data.push_back(cw_data); q_lv.push_back(cw_lv); q_pad.push_back(cw_pad);
      cw_data = '0; cw_lv = '0; cw_pad = '0; model_cnt = 0;
    end else model_cnt++;
  endtask

  task automatic send_byte(input logic [7:0] d, input bit last);
    bit done = 0;
    while (!done) begin
      @(negedge clk);
      in_valid = 1; in_data = d; in_last = last;
      #(CLK_P/2 - 1);
      if (in_ready) begin
        done = 1;
        model_accept(d, last);
      end else stalls++;
      @(posedge clk);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_valid = 0; in_last = 0;
    end
  endtask

  task automatic send_transfer(input int len, input bit use_last, input bit gaps);
    for (int i = 0; i < len; i++) begin
      if (gaps) idle($urandom % 3);
      send_byte(8'($urandom), use_last && (i == len - 1));
    end
  endtask

  task automatic renegotiate(input logic [6:0] a, input logic [6:0] b);
    @(negedge clk);
    in_valid = 0; in_last = 0;
    loc_cap = a; par_cap = b; reneg_req = 1;
    pend_model = 1;
    @(negedge clk);
    reneg_req = 0;
  endtask

  task automatic drain();
    idle(1);
    while (q_data.size() != 0 || out_valid) @(negedge clk);
    idle(2);
  endtask

  task automatic check_width(input string tag);
    int w = exp_width(loc_cap, par_cap);
    check(active_width == 6'(w), {tag, " width"}, ML*8'(active_width), ML*8'(w));
    check(degraded == (w == 1), "R3 degraded", ML*8'(degraded), ML*8'(w == 1));
  endtask

  // out_ready driver, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    case (rdy_mode)
      0: out_ready = ($urandom % 4) != 0;
      1: out_ready = 1;
      default: out_ready = 0;
    endcase
  end

  // word monitor: a word seen here with ready high is taken at the next edge
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (q_data.size() == 0) begin
        check(0, "R1 unexpected word", out_data, '0);
      end else begin
        check(out_data == q_data[0], "R1 lane data", out_data, q_data[0]);
        check(out_pad == q_pad[0], "R5 pad flags", ML*8'(out_pad), ML*8'(q_pad[0]));
        check(out_lane_valid == q_lv[0], "R6 lane valid", ML*8'(out_lane_valid),
              ML*8'(q_lv[0]));
        void'(q_data.pop_front()); void'(q_lv.pop_front()); void'(q_pad.pop_front());
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [ML*8-1:0] snap;
    void'($urandom(32'h5EED_1234));
    rdy_mode = 1;
    repeat (4) @(negedge clk);
    check(out_valid == 0, "R4 reset out_valid", ML*8'(out_valid), '0);
    check(in_ready == 0, "R4 reset in_ready", ML*8'(in_ready), '0);
    rst_n = 1;
    #1;
    check(in_ready == 0, "R4 negotiation cycle in_ready", ML*8'(in_ready), '0);
    idle(3);
    check_width("R3 full caps");

    // directed widths
    renegotiate(7'b0011111, 7'b1110001); idle(3); check_width("R3 twelve");
    send_transfer(30, 1, 0); drain();
    renegotiate(7'b0101010, 7'b1010100); idle(3); check_width("R3 fallback");
    renegotiate(7'b0000000, 7'b0000000); idle(3); check_width("R2 zero masks");

    // R8: one byte per cycle at width 1
    stalls = 0;
    send_transfer(20, 1, 0); drain();
    check(stalls == 0, "R8 full rate", ML*8'(stalls), '0);

    // R4: renegotiation mid-word is deferred
    renegotiate(7'h7F, 7'h7F); idle(3);
    send_transfer(3, 0, 0);
    renegotiate(7'h1F, 7'h7F); idle(3);
    check(active_width == 6'd32, "R4 deferred width", ML*8'(active_width), ML*8'(32));
    send_transfer(40, 1, 1); drain();
    check_width("R4 applied");

    // R7: back-pressure holds the word
    renegotiate(7'h07, 7'h7F); idle(3);
    rdy_mode = 2; idle(2);
    send_transfer(4, 0, 0);
    @(negedge clk);
    snap = out_data;
    in_valid = 1; in_data = 8'hA5; in_last = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(out_valid && !in_ready, "R7 stall", ML*8'({out_valid, in_ready}), ML*8'(2));
      check(out_data == snap, "R7 stable data", out_data, snap);
    end
    in_valid = 0;
    rdy_mode = 1; drain();

    // constrained random traffic with renegotiation
    rdy_mode = 0;
    for (int it = 0; it < 30; it++) begin
      if ($urandom % 3 == 0) begin
        renegotiate(7'($urandom), 7'($urandom));
        idle(2);
      end
      send_transfer(1 + $urandom % 40, 1, 1);
      if ($urandom % 4 == 0) begin
        drain(); check_width("R3 random");
      end
    end
    rdy_mode = 1; drain();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule